// File: doc/BRIEF.md
# Debug Address Comparator Bank

This block watches a 32-bit core's instruction fetch stream and its data accesses, and compares them against a set of programmable debug slots. It holds a number of instruction-breakpoint slots and data-watchpoint slots. Each slot has a value register holding an address and a control register holding the enable, the privilege filter, the access-type filter, an eight-bit byte-lane select and, on breakpoint slots, a mismatch flag. When a presented address satisfies an armed slot, the block raises a one-cycle event on the next clock edge and reports the lowest-numbered matching slot.

Software programs the slots through an indexed register port. Writes take effect on the clock edge, and reads return the selected register combinationally. A global monitor-enable bit gates every comparator, and a read-only identity word reports how many slots of each kind exist and a version code. Mismatch mode lets debug software step past an instruction: the slot then fires on any fetch outside its programmed word. The byte-lane field together with an aligned base address describes a watched region of 1, 2, 4 or 8 bytes.

Top module: `dbg_cmp_bank`

## Requirements
- R1: After reset every value register, every control register and the monitor-enable bit read as zero, and no event is raised.
- R2: The register index is 7 bits. With bit 6 clear, bits [5:4] select the kind (0 breakpoint value, 1 breakpoint control, 2 watchpoint value, 3 watchpoint control) and bits [3:0] select the slot. Slots that are not implemented read zero and ignore writes. Breakpoint control keeps bits [13:0], watchpoint control keeps bits [12:0], and the other control bits read zero. Value registers keep all 32 bits.
- R3: Index 0x40 reads the identity word: (watchpoint count − 1) in bits [31:28], (breakpoint count − 1) in bits [27:24], the version in bits [19:16], and zero elsewhere. Writes to it are ignored. Other indices with bit 6 set, apart from 0x41, read zero.
- R4: Index 0x41 bit 0 is the monitor-enable bit. It reads back as written. While it is clear, no breakpoint or watchpoint event is raised.
- R5: In normal mode a breakpoint slot matches when value[31:2] equals the fetch address bits [31:2] and the control lane bit (control bit 5 + fetch address[1:0]) is set. Control bits [12:5] form the lane field.
- R6: Control bit 1 allows user-mode accesses and control bit 2 allows privileged accesses. The access's privilege input (1 means privileged) selects which of the two is required.
- R7: With control bit 13 set, a breakpoint slot ignores its lane field and matches every fetch whose bits [31:2] differ from value[31:2].
- R8: A watchpoint uses the offset mask 7 when any of lane bits [7:4] is set, and 3 otherwise. It matches when the value equals the data address with the masked bits cleared and the lane bit indexed by the masked offset is set.
- R9: On watchpoints, control bit 3 allows loads and bit 4 allows stores. A slot with neither bit set never fires.
- R10: The event and the slot index are registered and appear on the clock edge after the address is presented, for one cycle. When several slots match, the lowest-numbered slot is reported.
- R11: Control bit 0 arms the slot. Writing zero to a control register, or clearing bit 0, stops that slot from firing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regIdx | input | 7 | Register index |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regIdx |
| fetchValid | input | 1 | Fetch address valid this cycle |
| fetchAddr | input | 32 | Instruction fetch address |
| fetchPriv | input | 1 | Fetch is privileged |
| dataValid | input | 1 | Data access valid this cycle |
| dataAddr | input | 32 | Data access address |
| dataStore | input | 1 | Access is a store (0 = load) |
| dataPriv | input | 1 | Data access is privileged |
| monEn | output | 1 | Current monitor-enable bit |
| bpHit | output | 1 | Breakpoint event pulse |
| bpSlot | output | BP_SW | Index of the reported breakpoint slot |
| wpHit | output | 1 | Watchpoint event pulse |
| wpSlot | output | WP_SW | Index of the reported watchpoint slot |

## Verification
The hardest condition to reach from the ports is several slots agreeing on one address while their lane, privilege, type and mismatch settings differ. Priority and filtering only show when those overlaps exist. The stimulus reprograms overlapping slots between sweeps and walks every byte address across a window spanning the watched words on both sides. It tries each privilege and access kind, and a reference model built from the requirements predicts hit and slot for every address. Mismatch mode is reached by arming a stepping slot alongside normal slots, so that the lowest-index rule must choose between the two kinds.

// File: rtl/dbgcmp_pkg.sv
package dbgcmp_pkg;
  // control register field positions
  localparam int CTL_EN       = 0;
  localparam int CTL_USR      = 1;
  localparam int CTL_PRV      = 2;
  localparam int CTL_LD       = 3;
  localparam int CTL_ST       = 4;
  localparam int CTL_LANE_LSB = 5;
  localparam int LANE_W       = 8;
  localparam int CTL_MISM     = 13;
  localparam int BP_CTL_W     = 14;
  localparam int WP_CTL_W     = 13;

  typedef enum logic [2:0] {
    RD_ZERO, RD_BPV, RD_BPC, RD_WPV, RD_WPC, RD_ID, RD_MON
  } rdSel_e;

  typedef struct packed {
    logic       wrBpVal;
    logic       wrBpCtl;
    logic       wrWpVal;
    logic       wrWpCtl;
    logic       wrMon;
    logic [3:0] slot;
    rdSel_e     rdSel;
  } regStrobe_t;
endpackage

// File: rtl/dbgcmp_ctl.sv
module dbgcmp_ctl
  import dbgcmp_pkg::*;
#(
  parameter int NUM_BP = 4,
  parameter int NUM_WP = 2
) (
  input  logic       regWe,
  input  logic [6:0] regIdx,
  output regStrobe_t strobe
);
  logic sysSpace;
  logic bpOk;
  logic wpOk;

  assign sysSpace = regIdx[6];
  assign bpOk     = int'(regIdx[3:0]) < NUM_BP;
  assign wpOk     = int'(regIdx[3:0]) < NUM_WP;

  always_comb begin
    strobe       = '0;
    strobe.slot  = regIdx[3:0];
    strobe.rdSel = RD_ZERO;
    if (sysSpace) begin
      if (regIdx[5:0] == 6'd0) begin
        strobe.rdSel = RD_ID;
      end else if (regIdx[5:0] == 6'd1) begin
        strobe.rdSel = RD_MON;
        strobe.wrMon = regWe;
      end
    end else begin
      unique case (regIdx[5:4])
        2'd0: if (bpOk) begin strobe.rdSel = RD_BPV; strobe.wrBpVal = regWe; end
        2'd1: if (bpOk) begin strobe.rdSel = RD_BPC; strobe.wrBpCtl = regWe; end
        2'd2: if (wpOk) begin strobe.rdSel = RD_WPV; strobe.wrWpVal = regWe; end
        default: if (wpOk) begin strobe.rdSel = RD_WPC; strobe.wrWpCtl = regWe; end
      endcase
    end
  end
endmodule

// File: rtl/dbgcmp_dp.sv
module dbgcmp_dp
  import dbgcmp_pkg::*;
#(
  parameter int          NUM_BP  = 4,
  parameter int          NUM_WP  = 2,
  parameter logic [3:0]  VERSION = 4'h5,
  parameter int          BP_SW   = 2,
  parameter int          WP_SW   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              fetchValid,
  input  logic [31:0]       fetchAddr,
  input  logic              fetchPriv,
  input  logic              dataValid,
  input  logic [31:0]       dataAddr,
  input  logic              dataStore,
  input  logic              dataPriv,
  output logic              monEn,
  output logic              bpHit,
  output logic [BP_SW-1:0]  bpSlot,
  output logic              wpHit,
  output logic [WP_SW-1:0]  wpSlot
);
  logic monQ;
  logic [NUM_BP-1:0][31:0] bpValAll, bpCtlAll;
  logic [NUM_WP-1:0][31:0] wpValAll, wpCtlAll;
  logic [NUM_BP-1:0] bpMatch;
  logic [NUM_WP-1:0] wpMatch;

  always_ff @(posedge clk) begin
    if (!rstN)             monQ <= 1'b0;
    else if (strobe.wrMon) monQ <= wdata[0];
  end
  assign monEn = monQ;

  for (genvar i = 0; i < NUM_BP; i++) begin : gBp
    logic [31:0]         valQ;
    logic [BP_CTL_W-1:0] ctlQ;
    logic [LANE_W-1:0]   lanes;
    logic                wordEq, laneOk, privOk;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        valQ <= '0;
        ctlQ <= '0;
      end else begin
        if (strobe.wrBpVal && strobe.slot == 4'(i)) valQ <= wdata;
        if (strobe.wrBpCtl && strobe.slot == 4'(i)) ctlQ <= wdata[BP_CTL_W-1:0];
      end
    end

    assign lanes  = ctlQ[CTL_LANE_LSB +: LANE_W];
    assign wordEq = valQ[31:2] == fetchAddr[31:2];
    assign laneOk = lanes[{1'b0, fetchAddr[1:0]}];
    assign privOk = fetchPriv ? ctlQ[CTL_PRV] : ctlQ[CTL_USR];
    assign bpMatch[i] = monQ & fetchValid & ctlQ[CTL_EN] & privOk &
                        (ctlQ[CTL_MISM] ? ~wordEq : (wordEq & laneOk));
    assign bpValAll[i] = valQ;
    assign bpCtlAll[i] = {{(32-BP_CTL_W){1'b0}}, ctlQ};
  end

  for (genvar j = 0; j < NUM_WP; j++) begin : gWp
    logic [31:0]         valQ;
    logic [WP_CTL_W-1:0] ctlQ;
    logic [LANE_W-1:0]   lanes;
    logic [2:0]          offMask;
    logic                baseEq, laneOk, privOk, typeOk;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        valQ <= '0;
        ctlQ <= '0;
      end else begin
        if (strobe.wrWpVal && strobe.slot == 4'(j)) valQ <= wdata;
        if (strobe.wrWpCtl && strobe.slot == 4'(j)) ctlQ <= wdata[WP_CTL_W-1:0];
      end
    end

    assign lanes   = ctlQ[CTL_LANE_LSB +: LANE_W];
    assign offMask = (|lanes[7:4]) ? 3'd7 : 3'd3;
    assign baseEq  = valQ == {dataAddr[31:3], dataAddr[2:0] & ~offMask};
    assign laneOk  = lanes[dataAddr[2:0] & offMask];
    assign privOk  = dataPriv ? ctlQ[CTL_PRV] : ctlQ[CTL_USR];
    assign typeOk  = dataStore ? ctlQ[CTL_ST] : ctlQ[CTL_LD];
    assign wpMatch[j] = monQ & dataValid & ctlQ[CTL_EN] & privOk & typeOk &
                        baseEq & laneOk;
    assign wpValAll[j] = valQ;
    assign wpCtlAll[j] = {{(32-WP_CTL_W){1'b0}}, ctlQ};
  end

  // lowest index wins
  logic             bpAny, wpAny;
  logic [BP_SW-1:0] bpIdx;
  logic [WP_SW-1:0] wpIdx;

  always_comb begin
    bpAny = 1'b0;
    bpIdx = '0;
    for (int k = NUM_BP - 1; k >= 0; k--) begin
      if (bpMatch[k]) begin
        bpAny = 1'b1;
        bpIdx = BP_SW'(k);
      end
    end
    wpAny = 1'b0;
    wpIdx = '0;
    for (int k = NUM_WP - 1; k >= 0; k--) begin
      if (wpMatch[k]) begin
        wpAny = 1'b1;
        wpIdx = WP_SW'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bpHit  <= 1'b0;
      bpSlot <= '0;
      wpHit  <= 1'b0;
      wpSlot <= '0;
    end else begin
      bpHit  <= bpAny;
      bpSlot <= bpIdx;
      wpHit  <= wpAny;
      wpSlot <= wpIdx;
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_BPV:  rdata = bpValAll[strobe.slot[BP_SW-1:0]];
      RD_BPC:  rdata = bpCtlAll[strobe.slot[BP_SW-1:0]];
      RD_WPV:  rdata = wpValAll[strobe.slot[WP_SW-1:0]];
      RD_WPC:  rdata = wpCtlAll[strobe.slot[WP_SW-1:0]];
      RD_ID:   rdata = {4'(NUM_WP - 1), 4'(NUM_BP - 1), 4'b0, VERSION, 16'b0};
      RD_MON:  rdata = {31'b0, monQ};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/dbg_cmp_bank.sv
module dbg_cmp_bank
  import dbgcmp_pkg::*;
#(
  parameter int         NUM_BP  = 4,
  parameter int         NUM_WP  = 2,
  parameter logic [3:0] VERSION = 4'h5,
  localparam int        BP_SW   = (NUM_BP > 1) ? $clog2(NUM_BP) : 1,
  localparam int        WP_SW   = (NUM_WP > 1) ? $clog2(NUM_WP) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [6:0]       regIdx,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic             fetchValid,
  input  logic [31:0]      fetchAddr,
  input  logic             fetchPriv,
  input  logic             dataValid,
  input  logic [31:0]      dataAddr,
  input  logic             dataStore,
  input  logic             dataPriv,
  output logic             monEn,
  output logic             bpHit,
  output logic [BP_SW-1:0] bpSlot,
  output logic             wpHit,
  output logic [WP_SW-1:0] wpSlot
);
  regStrobe_t strobe;

  dbgcmp_ctl #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP)) u_ctl (
    .regWe  (regWe),
    .regIdx (regIdx),
    .strobe (strobe)
  );

  dbgcmp_dp #(
    .NUM_BP(NUM_BP), .NUM_WP(NUM_WP), .VERSION(VERSION),
    .BP_SW(BP_SW), .WP_SW(WP_SW)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wdata      (regWdata),
    .rdata      (regRdata),
    .fetchValid (fetchValid),
    .fetchAddr  (fetchAddr),
    .fetchPriv  (fetchPriv),
    .dataValid  (dataValid),
    .dataAddr   (dataAddr),
    .dataStore  (dataStore),
    .dataPriv   (dataPriv),
    .monEn      (monEn),
    .bpHit      (bpHit),
    .bpSlot     (bpSlot),
    .wpHit      (wpHit),
    .wpSlot     (wpSlot)
  );
endmodule

// File: rtl/dbgcmp_chk.sv
module dbgcmp_chk #(
  parameter int NUM_BP = 4,
  parameter int NUM_WP = 2,
  parameter int BP_SW  = 2,
  parameter int WP_SW  = 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWe,
  input logic [6:0]       regIdx,
  input logic [31:0]      regWdata,
  input logic             fetchValid,
  input logic             dataValid,
  input logic             monEn,
  input logic             bpHit,
  input logic [BP_SW-1:0] bpSlot,
  input logic             wpHit,
  input logic [WP_SW-1:0] wpSlot
);
  // R4
  bp_needs_mon_chk: assert property (@(posedge clk) disable iff (!rstN)
    bpHit |-> $past(monEn));
  // R4
  wp_needs_mon_chk: assert property (@(posedge clk) disable iff (!rstN)
    wpHit |-> $past(monEn));
  // R4
  mon_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regIdx == 7'h41) |=> (monEn == $past(regWdata[0])));
  // R5
  bp_after_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    bpHit |-> $past(fetchValid));
  // R8
  wp_after_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    wpHit |-> $past(dataValid));
  // R10
  bp_slot_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bpHit |-> (int'(bpSlot) < NUM_BP));
  // R10
  wp_slot_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    wpHit |-> (int'(wpSlot) < NUM_WP));
endmodule

bind dbg_cmp_bank dbgcmp_chk #(
  .NUM_BP(NUM_BP), .NUM_WP(NUM_WP), .BP_SW(BP_SW), .WP_SW(WP_SW)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regWe      (regWe),
  .regIdx     (regIdx),
  .regWdata   (regWdata),
  .fetchValid (fetchValid),
  .dataValid  (dataValid),
  .monEn      (monEn),
  .bpHit      (bpHit),
  .bpSlot     (bpSlot),
  .wpHit      (wpHit),
  .wpSlot     (wpSlot)
);

// File: tb/dbg_cmp_bank_tb.sv
module dbg_cmp_bank_tb;
  localparam int         CLK_PERIOD = 10;
  localparam int         NUM_BP     = 4;
  localparam int         NUM_WP     = 2;
  localparam logic [3:0] VER        = 4'h5;
  localparam int         BP_SW      = 2;
  localparam int         WP_SW      = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [6:0] regIdx = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic fetchValid = 1'b0, fetchPriv = 1'b0;
  logic [31:0] fetchAddr = '0;
  logic dataValid = 1'b0, dataStore = 1'b0, dataPriv = 1'b0;
  logic [31:0] dataAddr = '0;
  logic monEn, bpHit, wpHit;
  logic [BP_SW-1:0] bpSlot;
  logic [WP_SW-1:0] wpSlot;

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  logic [31:0] mBpV [NUM_BP];
  logic [31:0] mBpC [NUM_BP];
  logic [31:0] mWpV [NUM_WP];
  logic [31:0] mWpC [NUM_WP];
  logic        mMon;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_cmp_bank #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP), .VERSION(VER)) u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regIdx(regIdx),
    .regWdata(regWdata), .regRdata(regRdata),
    .fetchValid(fetchValid), .fetchAddr(fetchAddr), .fetchPriv(fetchPriv),
    .dataValid(dataValid), .dataAddr(dataAddr), .dataStore(dataStore),
    .dataPriv(dataPriv), .monEn(monEn), .bpHit(bpHit), .bpSlot(bpSlot),
    .wpHit(wpHit), .wpSlot(wpSlot)
  );

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [6:0] idx);
    int s;
    s = int'(idx[3:0]);
    if (idx[6]) begin
      if (idx[5:0] == 6'd0) return {4'(NUM_WP-1), 4'(NUM_BP-1), 4'b0, VER, 16'b0};
      if (idx[5:0] == 6'd1) return {31'b0, mMon};
      return 32'h0;
    end
    case (idx[5:4])
      2'd0: return (s < NUM_BP) ? mBpV[s] : 32'h0;
      2'd1: return (s < NUM_BP) ? mBpC[s] : 32'h0;
      2'd2: return (s < NUM_WP) ? mWpV[s] : 32'h0;
      default: return (s < NUM_WP) ? mWpC[s] : 32'h0;
    endcase
  endfunction

  task automatic wr(input logic [6:0] idx, input logic [31:0] d);
    int s;
    s = int'(idx[3:0]);
    @(negedge clk);
    regWe = 1'b1; regIdx = idx; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
    if (idx[6]) begin
      if (idx[5:0] == 6'd1) mMon = d[0];
    end else begin
      case (idx[5:4])
        2'd0: if (s < NUM_BP) mBpV[s] = d;
        2'd1: if (s < NUM_BP) mBpC[s] = d & 32'h3FFF;
        2'd2: if (s < NUM_WP) mWpV[s] = d;
        default: if (s < NUM_WP) mWpC[s] = d & 32'h1FFF;
      endcase
    end
  endtask

  task automatic rd(input logic [6:0] idx, input string req);
    @(negedge clk);
    regIdx = idx;
    #1;
    chk(req, regRdata, expRead(idx));
  endtask

  function automatic logic [31:0] modelBp(input logic [31:0] a, input logic p);
    logic [31:0] r;
    r = 32'h0;
    for (int i = NUM_BP - 1; i >= 0; i--) begin
      logic [31:0] c;
      logic eq, m;
      c  = mBpC[i];
      eq = (mBpV[i][31:2] == a[31:2]);
      m  = mMon && c[0] && (p ? c[2] : c[1]) && (c[13] ? !eq : (eq && c[5 + a[1:0]]));
      if (m) r = 32'h100 | 32'(i);
    end
    return r;
  endfunction

  function automatic logic [31:0] modelWp(input logic [31:0] a, input logic st, input logic p);
    logic [31:0] r;
    r = 32'h0;
    for (int i = NUM_WP - 1; i >= 0; i--) begin
      logic [31:0] c;
      logic [7:0] lanes;
      logic [2:0] msk;
      logic m;
      c     = mWpC[i];
      lanes = c[12:5];
      msk   = (|lanes[7:4]) ? 3'd7 : 3'd3;
      m = mMon && c[0] && (p ? c[2] : c[1]) && (st ? c[4] : c[3]) &&
          (mWpV[i] == {a[31:3], a[2:0] & ~msk}) && lanes[a[2:0] & msk];
      if (m) r = 32'h100 | 32'(i);
    end
    return r;
  endfunction

  task automatic doFetch(input logic [31:0] a, input logic p, input string req);
    logic [31:0] e;
    @(negedge clk);
    fetchValid = 1'b1; fetchAddr = a; fetchPriv = p;
    e = modelBp(a, p);
    @(negedge clk);
    fetchValid = 1'b0;
    chk(req, bpHit ? (32'h100 | 32'(bpSlot)) : 32'h0, e);
  endtask

  task automatic doData(input logic [31:0] a, input logic st, input logic p, input string req);
    logic [31:0] e;
    @(negedge clk);
    dataValid = 1'b1; dataAddr = a; dataStore = st; dataPriv = p;
    e = modelWp(a, st, p);
    @(negedge clk);
    dataValid = 1'b0;
    chk(req, wpHit ? (32'h100 | 32'(wpSlot)) : 32'h0, e);
  endtask

  task automatic sweepFetch(input logic [31:0] base, input string req);
    for (int k = 0; k < 20; k++) begin
      doFetch(base + 32'(k), 1'b0, req);
      doFetch(base + 32'(k), 1'b1, req);
    end
  endtask

  task automatic sweepData(input logic [31:0] base, input string req);
    for (int k = 0; k < 24; k++) begin
      doData(base + 32'(k), 1'b0, 1'b0, req);
      doData(base + 32'(k), 1'b1, 1'b0, req);
      doData(base + 32'(k), 1'b1, 1'b1, req);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < NUM_BP; i++) begin mBpV[i] = 0; mBpC[i] = 0; end
    for (int i = 0; i < NUM_WP; i++) begin mWpV[i] = 0; mWpC[i] = 0; end
    mMon = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 R2 R3: reset state of the whole index space
    for (int k = 0; k < 128; k++) rd(7'(k), "R1");
    chk("R1", {30'b0, bpHit, wpHit}, 32'h0);

    // R2: readback, masked control bits, unimplemented slots
    wr(7'h00, 32'h0000_1003);
    rd(7'h00, "R2");
    wr(7'h10, 32'hFFFF_FFFF);
    rd(7'h10, "R2");
    wr(7'h30, 32'hFFFF_FFFF);
    rd(7'h30, "R2");
    wr(7'h05, 32'hDEAD_BEEF);
    rd(7'h05, "R2");
    wr(7'h23, 32'hDEAD_BEEF);
    rd(7'h23, "R2");
    // R3: identity word is read-only
    wr(7'h40, 32'h1234_5678);
    rd(7'h40, "R3");
    wr(7'h42, 32'hFFFF_FFFF);
    rd(7'h42, "R3");
    wr(7'h30, 32'h0);
    rd(7'h30, "R11");

    // R4: monitor disabled suppresses events
    wr(7'h00, 32'h0000_1000);
    wr(7'h10, 32'h0000_01E7);
    doFetch(32'h0000_1000, 1'b0, "R4");
    wr(7'h41, 32'h0000_0001);
    rd(7'h41, "R4");

    // R5: full word lanes, then upper halfword lanes
    sweepFetch(32'h0000_0FF8, "R5");
    wr(7'h10, 32'h0000_0187);
    sweepFetch(32'h0000_0FF8, "R5");

    // R6: user-only slot
    wr(7'h10, 32'h0000_01E3);
    doFetch(32'h0000_1000, 1'b0, "R6");
    doFetch(32'h0000_1000, 1'b1, "R6");
    wr(7'h10, 32'h0000_01E5);
    doFetch(32'h0000_1000, 1'b0, "R6");
    doFetch(32'h0000_1002, 1'b1, "R6");

    // R10 R11: priority among overlapping slots, disarm
    wr(7'h01, 32'h0000_1000);
    wr(7'h11, 32'h0000_01E7);
    wr(7'h02, 32'h0000_1000);
    wr(7'h12, 32'h0000_01E7);
    doFetch(32'h0000_1001, 1'b0, "R10");
    wr(7'h10, 32'h0);
    doFetch(32'h0000_1001, 1'b0, "R11");
    wr(7'h11, 32'h0000_01E6);
    doFetch(32'h0000_1001, 1'b0, "R11");

    // R10: pulse lasts one cycle
    @(negedge clk);
    chk("R10", {31'b0, bpHit}, 32'h0);

    // R7: mismatch stepping slot alongside a normal slot
    wr(7'h03, 32'h0000_2000);
    wr(7'h13, 32'h0000_2007);
    sweepFetch(32'h0000_1FFA, "R7");
    doFetch(32'h0000_1000, 1'b0, "R7");
    wr(7'h12, 32'h0);
    doFetch(32'h0000_1000, 1'b0, "R7");

    // R8 R9: single byte at offset 2, loads only
    wr(7'h13, 32'h0);
    wr(7'h20, 32'h0000_3000);
    wr(7'h30, 32'h0000_008F);
    sweepData(32'h0000_2FF8, "R8");
    // R8 R9: eight-byte region, stores only
    wr(7'h21, 32'h0000_4000);
    wr(7'h31, 32'h0000_1FF7);
    sweepData(32'h0000_3FF8, "R9");
    // R8 R9: upper halfword, both kinds
    wr(7'h30, 32'h0000_019F);
    sweepData(32'h0000_2FF8, "R9");
    // R10: overlapping watchpoints
    wr(7'h20, 32'h0000_4000);
    wr(7'h30, 32'h0000_01FF);
    sweepData(32'h0000_3FFC, "R10");
    // R6: privileged-only watchpoint
    wr(7'h31, 32'h0000_1FFD);
    doData(32'h0000_4006, 1'b1, 1'b0, "R6");
    doData(32'h0000_4006, 1'b1, 1'b1, "R6");

    // R4: turning monitor off again
    wr(7'h41, 32'h0);
    rd(7'h41, "R4");
    doData(32'h0000_4000, 1'b1, 1'b1, "R4");
    doFetch(32'h0000_5000, 1'b0, "R4");

    summary();
  end
endmodule